// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters over an asynchronous serial line. A host writes a character into a one-entry holding register. From there it moves into a frame shift register, which sends one low start bit, eight or nine data bits (least significant first) and one high stop bit. Because of the holding register, the host can queue the next character while the current frame is still on the line. The next frame then follows the previous stop bit with no idle gap.

Bit timing comes from an oversampling strobe that runs at sixteen times the bit rate. An internal prescaler divides this strobe down to one bit tick per bit period. Two status flags report the transmitter's state. The holding-empty flag shows that the host may write another character. The transmit-done flag shows that the line has gone quiet after the last stop bit. Each flag drives an interrupt request, and each request has its own enable. While the transmitter is disabled it releases the line: the output-enable goes low and the data output rests high.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, serial_out is 1, serial_oe is 0, hold_empty is 1, tx_done is 0 and both interrupt requests are 0.
- R2: A wr_stb pulse clears hold_empty at the next clock edge. If no frame is being shifted, the character moves into the shift register on the following edge, and hold_empty returns to 1 on that edge.
- R3: A character written while a frame is being shifted stays in the holding register, with hold_empty at 0, until that frame's stop bit is on the line. It moves into the shift register on the next clock edge. Its start bit appears on the next bit tick, so the stop bit before it lasts exactly one bit period.
- R4: With nine_mode at 0, a frame is 10 bits long: 0, then wr_data bit 0 through bit 7, then 1.
- R5: With nine_mode at 1, a frame is 11 bits long: 0, wr_data bit 0 through bit 7, then the wr_ext value captured with the write, then 1. nine_mode is sampled when the character moves into the shift register.
- R6: The line changes only on a bit tick. A bit tick is the OVERSAMPLE-th os_tick pulse (16 by default). The start bit appears on the first bit tick after the character has moved into the shift register.
- R7: tx_done goes to 1 on the bit tick that ends a full bit period of the stop bit, provided no character is waiting. It goes to 0 on a done_clr pulse, or when a character moves into the shift register.
- R8: empty_irq is hold_empty gated by empty_ie. done_irq is tx_done gated by done_ie.
- R9: While tx_en is 0, serial_oe is 0 and serial_out is 1, any frame in progress is dropped, and no character leaves the holding register. A character written while disabled starts moving out on the first edge after tx_en returns to 1.
- R10: Between frames, and after the last frame, serial_out stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; 0 releases the line |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| wr_stb | input | 1 | Host write of a character into the holding register |
| wr_data | input | 8 | Character data bits |
| wr_ext | input | 1 | Ninth data bit, captured with the write |
| nine_mode | input | 1 | 1 selects frames with nine data bits |
| done_clr | input | 1 | Clear strobe for tx_done |
| empty_ie | input | 1 | Enable for empty_irq |
| done_ie | input | 1 | Enable for done_irq |
| serial_out | output | 1 | Serial data line |
| serial_oe | output | 1 | Line drive enable |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Line has gone quiet after the last stop bit |
| empty_irq | output | 1 | Interrupt request for holding-empty |
| done_irq | output | 1 | Interrupt request for transmit-done |

## Verification
The hardest situation to reach from the ports is the handover at the stop-bit boundary. A second character has to arrive in the middle of a frame. Then, in the cycle after the stop bit reaches the line, the bench must see that the character is taken, that tx_done stays low, and that the new start bit comes exactly one bit period after the stop bit. To get there, the bench writes the second character one bit tick into the first frame. It counts bit ticks by issuing os_tick in whole groups of sixteen, so it knows the prescaler phase. It then samples in the single cycle between the stop-bit tick and the load.

A second hard case is a transmitter disabled in mid-frame with a character written while it is off. The bench covers this by writing during the disabled window, checking that the character is still held, and then re-enabling.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned FRAME_W = CHAR_W + 3;
    localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [LEFT_W-1:0]  left_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ext;
    } char_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_SEND = 2'd1,
        ENG_STOP = 2'd2
    } eng_state_e;

    // Start bit at position 0, data above it, stop (and fill) bits set to 1.
    function automatic frame_t build_frame(input char_t c, input logic nine);
        frame_t f;
        f = '1;
        f[0] = 1'b0;
        f[CHAR_W:1] = c.data;
        if (nine) begin
            f[CHAR_W+1] = c.ext;
        end
        return f;
    endfunction

    function automatic left_t frame_bits(input logic nine);
        return nine ? left_t'(CHAR_W + 3) : left_t'(CHAR_W + 2);
    endfunction

endpackage

// File: rtl/tx_bit_prescaler.sv
module tx_bit_prescaler #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    output logic bit_tick
);
    localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (os_tick) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign bit_tick = os_tick && (phase == LAST);
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
    import dbuf_uart_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  char_t wr_char,
    input  logic  take,
    output char_t held,
    output logic  full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            full <= 1'b0;
        end else begin
            if (wr_stb) begin
                held <= wr_char;
            end
            full <= wr_stb | (full & ~take);
        end
    end
endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
    import dbuf_uart_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  bit_tick,
    input  logic  hold_full,
    input  char_t held,
    input  logic  nine_mode,
    output logic  take,
    output logic  line,
    output logic  frame_done
);
    eng_state_e state;
    frame_t     sreg;
    left_t      left;

    // The shift register counts as empty outside ENG_SEND.
    assign take       = enable && hold_full && (state != ENG_SEND);
    assign frame_done = enable && (state == ENG_STOP) && bit_tick && !take;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= ENG_IDLE;
            sreg  <= '1;
            left  <= '0;
            line  <= 1'b1;
        end else if (take) begin
            sreg  <= build_frame(held, nine_mode);
            left  <= frame_bits(nine_mode);
            state <= ENG_SEND;
        end else begin
            unique case (state)
                ENG_SEND: begin
                    if (bit_tick) begin
                        line <= sreg[0];
                        sreg <= {1'b1, sreg[FRAME_W-1:1]};
                        left <= left - 1'b1;
                        if (left == left_t'(1)) begin
                            state <= ENG_STOP;
                        end
                    end
                end
                ENG_STOP: begin
                    if (bit_tick) begin
                        state <= ENG_IDLE;
                    end
                end
                default: begin
                    line <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/tx_status.sv
module tx_status (
    input  logic clk,
    input  logic rst,
    input  logic hold_full,
    input  logic take,
    input  logic frame_done,
    input  logic done_clr,
    input  logic empty_ie,
    input  logic done_ie,
    output logic hold_empty,
    output logic tx_done,
    output logic empty_irq,
    output logic done_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
        end else if (frame_done) begin
            tx_done <= 1'b1;
        end else if (done_clr || take) begin
            tx_done <= 1'b0;
        end
    end

    assign hold_empty = ~hold_full;
    assign empty_irq  = hold_empty & empty_ie;
    assign done_irq   = tx_done & done_ie;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              os_tick,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_ext,
    input  logic              nine_mode,
    input  logic              done_clr,
    input  logic              empty_ie,
    input  logic              done_ie,
    output logic              serial_out,
    output logic              serial_oe,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              empty_irq,
    output logic              done_irq
);
    logic  bit_tick;
    logic  hold_full;
    logic  take;
    logic  line;
    logic  frame_done;
    char_t held;
    char_t wr_char;

    assign wr_char = '{data: wr_data, ext: wr_ext};

    tx_bit_prescaler #(.OVERSAMPLE(OVERSAMPLE)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    tx_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_char (wr_char),
        .take    (take),
        .held    (held),
        .full    (hold_full)
    );

    tx_shift_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .enable     (tx_en),
        .bit_tick   (bit_tick),
        .hold_full  (hold_full),
        .held       (held),
        .nine_mode  (nine_mode),
        .take       (take),
        .line       (line),
        .frame_done (frame_done)
    );

    tx_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .hold_full  (hold_full),
        .take       (take),
        .frame_done (frame_done),
        .done_clr   (done_clr),
        .empty_ie   (empty_ie),
        .done_ie    (done_ie),
        .hold_empty (hold_empty),
        .tx_done    (tx_done),
        .empty_irq  (empty_irq),
        .done_irq   (done_irq)
    );

    assign serial_oe  = tx_en;
    assign serial_out = tx_en ? line : 1'b1;
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_stb,
    input logic done_clr,
    input logic bit_tick,
    input logic serial_out,
    input logic serial_oe,
    input logic hold_empty,
    input logic tx_done,
    input logic empty_irq,
    input logic done_irq
);
    // R9
    line_released_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (serial_out && !serial_oe));

    // R2
    write_fills_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !hold_empty);

    // R6
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && (serial_out != $past(serial_out))) |-> $past(bit_tick));

    // R7
    done_sets_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> $past(hold_empty));

    // R7
    done_clears_by_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_done) |-> ($past(done_clr) || !$past(hold_empty)));

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty_irq || hold_empty) && (!done_irq || tx_done));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .wr_stb     (wr_stb),
    .done_clr   (done_clr),
    .bit_tick   (bit_tick),
    .serial_out (serial_out),
    .serial_oe  (serial_oe),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .empty_irq  (empty_irq),
    .done_irq   (done_irq)
);

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb;
    localparam int OS = 16;

    typedef struct packed {
        logic [7:0]  data;
        logic        nine;
        logic        ext;
        logic [10:0] frame;
        logic [3:0]  len;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'h55, 1'b0, 1'b0, 11'h6AA, 4'd10},
        '{8'hA3, 1'b0, 1'b0, 11'h746, 4'd10},
        '{8'h00, 1'b1, 1'b1, 11'h600, 4'd11},
        '{8'hFF, 1'b1, 1'b0, 11'h5FE, 4'd11},
        '{8'h80, 1'b0, 1'b1, 11'h700, 4'd10}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, os_tick = 1'b0, wr_stb = 1'b0, wr_ext = 1'b0;
    logic nine_mode = 1'b0, done_clr = 1'b0, empty_ie = 1'b0, done_ie = 1'b0;
    logic [7:0] wr_data = '0;
    logic serial_out, serial_oe, hold_empty, tx_done, empty_irq, done_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dbuf_uart_tx u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .os_tick(os_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_ext(wr_ext),
        .nine_mode(nine_mode), .done_clr(done_clr), .empty_ie(empty_ie),
        .done_ie(done_ie), .serial_out(serial_out), .serial_oe(serial_oe),
        .hold_empty(hold_empty), .tx_done(tx_done), .empty_irq(empty_irq),
        .done_irq(done_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d, input logic e);
        wr_data = d;
        wr_ext  = e;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic bit_period();
        for (int i = 0; i < OS; i++) begin
            os_tick = 1'b1;
            @(negedge clk);
        end
        os_tick = 1'b0;
    endtask

    task automatic pulse_clr();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic expect_bits(input logic [10:0] fr, input int from, input int len, input string req);
        for (int k = from; k < len; k++) begin
            bit_period();
            check(req, serial_out, fr[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R1 reset state
        check("R1 out", serial_out, 1);
        check("R1 oe", serial_oe, 0);
        check("R1 empty", hold_empty, 1);
        check("R1 done", tx_done, 0);
        check("R1 irqs", {empty_irq, done_irq}, 0);

        tx_en = 1'b1;
        idle();

        // Vector table: R4 / R5 framing, R2 load, R7 done
        for (int i = 0; i < 5; i++) begin
            nine_mode = VEC[i].nine;
            write_char(VEC[i].data, VEC[i].ext);
            check("R2 write clears empty", hold_empty, 0);
            idle();
            check("R2 immediate load", hold_empty, 1);
            expect_bits(VEC[i].frame, 0, int'(VEC[i].len), VEC[i].nine ? "R5 frame" : "R4 frame");
            check("R7 done not before full stop", tx_done, 0);
            bit_period();
            check("R7 done after stop period", tx_done, 1);
            pulse_clr();
            check("R7 done cleared by strobe", tx_done, 0);
        end
        nine_mode = 1'b0;

        // R6 start bit only on the OVERSAMPLE-th os_tick
        write_char(8'h3C, 1'b0);
        idle();
        for (int i = 0; i < OS - 1; i++) begin
            os_tick = 1'b1;
            @(negedge clk);
        end
        os_tick = 1'b0;
        check("R6 no change before tick", serial_out, 1);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        check("R6 start on first tick", serial_out, 0);
        expect_bits(11'h678, 1, 10, "R6 frame");
        bit_period();
        check("R7 done", tx_done, 1);
        // R10 line rests high after last frame
        bit_period();
        check("R10 idle high", serial_out, 1);

        // R3 back-to-back: second char written mid-frame
        write_char(8'h0F, 1'b0);
        check("R7 done cleared by load pending", tx_done, 1);
        idle();
        check("R7 done cleared by load", tx_done, 0);
        bit_period();
        check("R3 first start", serial_out, 0);
        write_char(8'hF0, 1'b0);
        check("R3 held while busy", hold_empty, 0);
        expect_bits(11'h61E, 1, 10, "R4 first frame");
        check("R3 still held at stop", hold_empty, 0);
        idle();
        check("R3 handover after stop", hold_empty, 1);
        check("R3 no done on handover", tx_done, 0);
        check("R10 stop holds line", serial_out, 1);
        expect_bits(11'h7E0, 0, 10, "R3 second frame");
        bit_period();
        check("R7 done after second", tx_done, 1);

        // R8 interrupt gating
        check("R8 both masked", {empty_irq, done_irq}, 0);
        empty_ie = 1'b1;
        #1 check("R8 empty irq", {empty_irq, done_irq}, 2'b10);
        done_ie = 1'b1;
        #1 check("R8 done irq", {empty_irq, done_irq}, 2'b11);
        @(negedge clk);
        pulse_clr();
        check("R8 done irq cleared", done_irq, 0);
        write_char(8'h81, 1'b0);
        check("R8 empty irq drops", empty_irq, 0);
        idle();
        check("R8 empty irq back", empty_irq, 1);
        empty_ie = 1'b0;
        done_ie  = 1'b0;

        // R9 disable mid-frame
        bit_period();
        check("R9 start before disable", serial_out, 0);
        tx_en = 1'b0;
        #1;
        check("R9 oe low", serial_oe, 0);
        check("R9 line high", serial_out, 1);
        @(negedge clk);
        write_char(8'h42, 1'b0);
        idle();
        check("R9 held while disabled", hold_empty, 0);
        bit_period();
        check("R9 line quiet", serial_out, 1);
        check("R9 still held", hold_empty, 0);
        check("R9 no done", tx_done, 0);
        tx_en = 1'b1;
        idle();
        check("R9 loads on enable", hold_empty, 1);
        expect_bits(11'h684, 0, 10, "R9 frame after enable");
        bit_period();
        check("R9 done after frame", tx_done, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule